// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a short queue of instruction bytes filled ahead of a decoder. It reads whole 32-bit words from a word-addressed memory port, drops the bytes that precede the current fetch point, and appends the rest to a six-byte queue in stream order. The oldest queued byte always appears as an 8-bit operand, and the oldest two appear as a 16-bit operand. Both are shown whether or not the decoder needs them.

The decoder removes one or two bytes per cycle through a valid/ready consume port. `cons_valid` is the request and `cons_two` selects a 2-byte take. `cons_ready` is high only when the queue holds enough bytes for the requested size, and a transfer happens in a cycle where both `cons_valid` and `cons_ready` are high. When the queue is short, the decoder waits. The memory request side is also valid/ready. Once `mem_req_valid` is raised it stays high with a stable address until `mem_req_ready` accepts it, except that a redirect may withdraw it. Responses have no back-pressure, because the block only asks for a word when the whole word is sure to fit. A redirect loads a new byte address, empties the queue, and restarts fetching at the word that contains that address.

Top module: `ibyte_prefetch`

## Requirements
- R1: While reset is held, `op_valid8`, `op_valid16` and `cons_ready` are low. `mem_req_valid` is high with `mem_req_addr` equal to RESET_PC divided by 4. After reset, the first byte presented is the byte at RESET_PC.
- R2: The byte at byte address 4·w+k sits in bits 8k+7..8k of the word at word address w (little-endian lanes). Bytes leave through `op8` in increasing address order, with none skipped or repeated. `op8` holds the oldest queued byte, and `op_valid8` is high exactly when at least one byte is queued.
- R3: `op16` is {oldest byte, next byte}, with the oldest byte in bits 15..8. `op_valid16` is high exactly when at least two bytes are queued.
- R4: `cons_ready` equals `op_valid8` for a 1-byte take (`cons_two`=0) and `op_valid16` for a 2-byte take. It is low during a redirect. A transfer removes 1 or 2 bytes. When there is no transfer, the head byte stays unchanged, and a take from an empty queue is refused.
- R5: A word is requested only when at most 2 bytes are queued and no word is outstanding. The queue never holds more than 6 bytes.
- R6: Each accepted request advances the word address by exactly one. The increment comes from a dedicated incrementer.
- R7: A redirect empties the queue by the next cycle. The next request is for the word that contains the new address, and the first byte presented is the byte at that address.
- R8: A response to a request issued before a redirect is discarded, so none of its bytes ever appear.
- R9: When a take and an arriving word occur in the same cycle, the queue changes by the net amount and the stream order is kept.
- R10: A raised `mem_req_valid` stays high with a stable `mem_req_addr` until it is accepted, unless a redirect withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Load a new fetch byte address |
| redir_pc | input | ADDR_W | New fetch byte address |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W-2 | Requested word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word, lane k = byte 4w+k |
| op_valid8 | output | 1 | At least one byte queued |
| op8 | output | 8 | Oldest queued byte |
| op_valid16 | output | 1 | At least two bytes queued |
| op16 | output | 16 | Oldest two bytes, earlier byte high |
| cons_valid | input | 1 | Decoder wants to take bytes |
| cons_two | input | 1 | Take two bytes instead of one |
| cons_ready | output | 1 | Enough bytes for the requested take |

## Verification
A wrong occupancy count shows at the ports within a cycle. It appears as a valid flag that claims a byte which is not there, as a request raised while the queue has no room, or as a byte duplicated or lost in the `op8` sequence. A mis-aligned lane shift or skip count appears as soon as the first word after a reset or redirect lands: the head byte is not the addressed byte. A response that escaped the stale filter injects bytes from the old address a few cycles after the redirect. Every byte leaving the queue is compared against a pattern computed from its address, so any of these faults is reported in the cycle it becomes visible.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  localparam int WORD_BYTES = 4;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = WORD_BYTES * BYTE_W;
  localparam int LANE_W     = $clog2(WORD_BYTES);
endpackage

// File: rtl/ibp_fetch_ctrl.sv
// Word-address register, its incrementer, and the one-outstanding request tracker.
module ibp_fetch_ctrl
  import ibp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUF_BYTES = 6,
  parameter int OCC_W = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     redir_valid,
  input  logic [ADDR_W-1:0]        redir_pc,
  input  logic [OCC_W-1:0]         occ,
  input  logic                     mem_req_ready,
  input  logic                     mem_rsp_valid,
  output logic                     mem_req_valid,
  output logic [ADDR_W-LANE_W-1:0] mem_req_addr,
  output logic                     word_accept,
  output logic [LANE_W-1:0]        skip_lanes
);
  localparam int WADDR_W = ADDR_W - LANE_W;
  localparam logic [OCC_W-1:0] ROOM_LIMIT = OCC_W'(BUF_BYTES - WORD_BYTES);

  logic [WADDR_W-1:0] waddr_q, waddr_inc;
  logic [LANE_W-1:0]  skip_q;
  logic               pending_q, stale_q;
  logic               room, fire;

  // dedicated incrementer, separate from any datapath adder
  assign waddr_inc = waddr_q + WADDR_W'(1);

  assign room          = (occ <= ROOM_LIMIT);
  assign mem_req_valid = !pending_q && room && !redir_valid;
  assign fire          = mem_req_valid && mem_req_ready;
  assign mem_req_addr  = waddr_q;
  assign word_accept   = mem_rsp_valid && pending_q && !stale_q && !redir_valid;
  assign skip_lanes    = skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr_q   <= RESET_PC[ADDR_W-1:LANE_W];
      skip_q    <= RESET_PC[LANE_W-1:0];
      pending_q <= 1'b0;
      stale_q   <= 1'b0;
    end else if (redir_valid) begin
      waddr_q   <= redir_pc[ADDR_W-1:LANE_W];
      skip_q    <= redir_pc[LANE_W-1:0];
      pending_q <= pending_q && !mem_rsp_valid;
      stale_q   <= pending_q && !mem_rsp_valid;
    end else begin
      if (fire) begin
        waddr_q   <= waddr_inc;
        pending_q <= 1'b1;
      end
      if (mem_rsp_valid && pending_q) begin
        pending_q <= 1'b0;
        stale_q   <= 1'b0;
        if (!stale_q) skip_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ibp_byte_queue.sv
// Six-byte shift queue: head at byte 0, take from the head, append at the tail.
module ibp_byte_queue
  import ibp_pkg::*;
#(
  parameter int BUF_BYTES = 6,
  parameter int OCC_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [1:0]              take_n,
  input  logic                    word_in_valid,
  input  logic [WORD_W-1:0]       word_in,
  input  logic [LANE_W-1:0]       skip,
  output logic [OCC_W-1:0]        occ,
  output logic [BUF_BYTES*BYTE_W-1:0] bytes_out
);
  localparam int BUF_W = BUF_BYTES * BYTE_W;
  localparam int CNT_W = OCC_W + 1;

  logic [BUF_W-1:0]  q_r, q_shift, q_ext, q_next;
  logic [WORD_W-1:0] aligned;
  logic [OCC_W-1:0]  occ_r, base;
  logic [CNT_W-1:0]  add_n, tail;

  assign base    = occ_r - OCC_W'(take_n);
  assign add_n   = word_in_valid ? (CNT_W'(WORD_BYTES) - CNT_W'(skip)) : '0;
  assign tail    = {1'b0, base} + add_n;
  assign q_shift = q_r >> {take_n, 3'b000};
  assign aligned = word_in >> {skip, 3'b000};
  assign q_ext   = BUF_W'(aligned) << {base, 3'b000};

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_slot
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    always_comb begin
      if (IDX >= {1'b0, base} && IDX < tail)
        q_next[i*BYTE_W +: BYTE_W] = q_ext[i*BYTE_W +: BYTE_W];
      else
        q_next[i*BYTE_W +: BYTE_W] = q_shift[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_r <= '0;
      q_r   <= '0;
    end else if (flush) begin
      occ_r <= '0;
    end else begin
      occ_r <= OCC_W'(tail);
      q_r   <= q_next;
    end
  end

  assign occ       = occ_r;
  assign bytes_out = q_r;
endmodule

// File: rtl/ibp_operand_view.sv
// Presents head operands and resolves the consume handshake.
module ibp_operand_view
  import ibp_pkg::*;
#(
  parameter int BUF_BYTES = 6,
  parameter int OCC_W = 3
) (
  input  logic [BUF_BYTES*BYTE_W-1:0] bytes_in,
  input  logic [OCC_W-1:0]            occ,
  input  logic                        redir_valid,
  input  logic                        cons_valid,
  input  logic                        cons_two,
  output logic                        op_valid8,
  output logic [7:0]                  op8,
  output logic                        op_valid16,
  output logic [15:0]                 op16,
  output logic                        cons_ready,
  output logic [1:0]                  take_n
);
  assign op_valid8  = (occ >= OCC_W'(1));
  assign op_valid16 = (occ >= OCC_W'(2));
  assign op8        = bytes_in[7:0];
  assign op16       = {bytes_in[7:0], bytes_in[15:8]};
  assign cons_ready = !redir_valid && (cons_two ? op_valid16 : op_valid8);
  assign take_n     = (cons_valid && cons_ready) ? (cons_two ? 2'd2 : 2'd1) : 2'd0;
endmodule

// File: rtl/ibyte_prefetch.sv
module ibyte_prefetch
  import ibp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUF_BYTES = 6,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-3:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              op_valid8,
  output logic [7:0]        op8,
  output logic              op_valid16,
  output logic [15:0]       op16,
  input  logic              cons_valid,
  input  logic              cons_two,
  output logic              cons_ready
);
  localparam int OCC_W = $clog2(BUF_BYTES + 1);

  logic [OCC_W-1:0]            occ;
  logic [BUF_BYTES*BYTE_W-1:0] q_bytes;
  logic                        word_accept;
  logic [LANE_W-1:0]           skip_lanes;
  logic [1:0]                  take_n;

  ibp_fetch_ctrl #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .OCC_W(OCC_W), .RESET_PC(RESET_PC)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .occ(occ),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .word_accept(word_accept), .skip_lanes(skip_lanes)
  );

  ibp_byte_queue #(.BUF_BYTES(BUF_BYTES), .OCC_W(OCC_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .flush(redir_valid), .take_n(take_n),
    .word_in_valid(word_accept), .word_in(mem_rsp_data), .skip(skip_lanes),
    .occ(occ), .bytes_out(q_bytes)
  );

  ibp_operand_view #(.BUF_BYTES(BUF_BYTES), .OCC_W(OCC_W)) u_view (
    .bytes_in(q_bytes), .occ(occ), .redir_valid(redir_valid),
    .cons_valid(cons_valid), .cons_two(cons_two),
    .op_valid8(op_valid8), .op8(op8), .op_valid16(op_valid16), .op16(op16),
    .cons_ready(cons_ready), .take_n(take_n)
  );
endmodule

// File: rtl/ibyte_prefetch_chk.sv
module ibyte_prefetch_chk #(
  parameter int AW = 30,
  parameter int OCC_W = 3,
  parameter int BUF_BYTES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             redir_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             op_valid8,
  input logic             op_valid16,
  input logic [7:0]       op8,
  input logic             cons_valid,
  input logic             cons_two,
  input logic             cons_ready,
  input logic [OCC_W-1:0] occ
);
  logic [AW-1:0] last_addr;
  logic          seq_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_ok    <= 1'b0;
      last_addr <= '0;
    end else if (redir_valid) begin
      seq_ok <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      seq_ok    <= 1'b1;
      last_addr <= mem_req_addr;
    end
  end

  assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(BUF_BYTES));
  assert_req_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> occ <= OCC_W'(BUF_BYTES - 4));
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && seq_ok) |-> mem_req_addr == last_addr + AW'(1));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (redir_valid || (mem_req_valid && $stable(mem_req_addr))));
  assert_pair_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid16 |-> op_valid8);
  assert_ready_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && !redir_valid) |-> cons_ready == (cons_two ? op_valid16 : op_valid8));
  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid8 && !(cons_valid && cons_ready) && !redir_valid) |=> (op_valid8 && $stable(op8)));
  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !op_valid8);
endmodule

bind ibyte_prefetch ibyte_prefetch_chk #(
  .AW(ADDR_W - 2), .OCC_W(OCC_W), .BUF_BYTES(BUF_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .op_valid8(op_valid8), .op_valid16(op_valid16),
  .op8(op8), .cons_valid(cons_valid), .cons_two(cons_two),
  .cons_ready(cons_ready), .occ(occ)
);

// File: tb/sim_ibyte_prefetch.sv
module sim_ibyte_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BOOT_PC = 32'h13;

  typedef struct packed {
    logic        redir;
    logic [15:0] pc;
    logic        cons;
    logic        two;
    logic        slow;
    logic [5:0]  reps;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 6'd20},
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd20},
    '{1'b1, 16'h0101, 1'b0, 1'b0, 1'b0, 6'd1},
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 6'd30},
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 6'd15},
    '{1'b1, 16'h0202, 1'b0, 1'b0, 1'b0, 6'd1},
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd5},
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd25},
    '{1'b1, 16'h0307, 1'b1, 1'b1, 1'b0, 6'd1},
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 6'd3},
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd3},
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 6'd3},
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 6'd40},
    '{1'b1, 16'h0FFE, 1'b0, 1'b0, 1'b1, 6'd1},
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 6'd12},
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd30}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_pc = '0;
  logic        mem_req_valid, mem_req_ready;
  logic [29:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        op_valid8, op_valid16, cons_ready;
  logic [7:0]  op8;
  logic [15:0] op16;
  logic        cons_valid = 1'b0, cons_two = 1'b0;

  int unsigned checks = 0, errors = 0;
  logic [31:0] exp_pc;
  logic        mem_en = 1'b0, slow = 1'b0, tog = 1'b0;
  int          lat = 1;
  int          q_cnt = 0;
  logic [29:0] q_addr = '0;
  logic        done = 1'b0;

  ibyte_prefetch #(.ADDR_W(32), .BUF_BYTES(6), .RESET_PC(BOOT_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .op_valid8(op_valid8), .op8(op8),
    .op_valid16(op_valid16), .op16(op16), .cons_valid(cons_valid),
    .cons_two(cons_two), .cons_ready(cons_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a * 32'd7 + 32'd3) ^ a[15:8];
  endfunction

  // memory model: one outstanding word, fixed latency
  assign mem_req_ready = mem_en & (~slow | tog);
  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_req_valid && mem_req_ready) begin
      q_cnt  <= lat;
      q_addr <= mem_req_addr;
    end else if (q_cnt > 0) begin
      q_cnt <= q_cnt - 1;
    end
  end
  always @(negedge clk) begin
    mem_rsp_valid = (q_cnt == 1);
    mem_rsp_data  = {pat({q_addr, 2'd3}), pat({q_addr, 2'd2}),
                     pat({q_addr, 2'd1}), pat({q_addr, 2'd0})};
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // called at a negedge; ends at the next negedge
  task automatic step(input logic rd, input logic [31:0] pc, input logic cv, input logic two);
    if (op_valid8)
      chk(op8 == pat(exp_pc), "R2 R9 head byte", 32'(op8), 32'(pat(exp_pc)));
    if (op_valid16)
      chk(op16 == {pat(exp_pc), pat(exp_pc + 32'd1)}, "R3 operand pair",
          32'(op16), 32'({pat(exp_pc), pat(exp_pc + 32'd1)}));
    redir_valid = rd; redir_pc = pc; cons_valid = cv; cons_two = two;
    #1;
    if (cv)
      chk(cons_ready == (!rd && (two ? op_valid16 : op_valid8)), "R4 ready rule",
          32'(cons_ready), 32'(!rd && (two ? op_valid16 : op_valid8)));
    if (rd) exp_pc = pc;
    else if (cv && cons_ready) exp_pc = exp_pc + (two ? 32'd2 : 32'd1);
    @(negedge clk);
    redir_valid = 1'b0; cons_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] start;
    exp_pc = BOOT_PC;
    // reset state (R1)
    repeat (3) @(negedge clk);
    cons_valid = 1'b1; cons_two = 1'b0; #1;
    chk(!op_valid8 && !op_valid16, "R1 no bytes in reset", 32'({op_valid8, op_valid16}), 0);
    chk(!cons_ready, "R1 ready low in reset", 32'(cons_ready), 0);
    chk(mem_req_valid && mem_req_addr == 30'(BOOT_PC >> 2), "R1 reset request",
        32'(mem_req_addr), BOOT_PC >> 2);
    cons_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; mem_en = 1'b1;
    repeat (6) step(1'b0, 0, 1'b0, 1'b0);
    chk(op_valid8 && op8 == pat(BOOT_PC), "R1 first byte at reset pc", 32'(op8), 32'(pat(BOOT_PC)));

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      slow = VEC[v].slow;
      for (int r = 0; r < int'(VEC[v].reps); r++)
        step(VEC[v].redir, 32'(VEC[v].pc), VEC[v].cons, VEC[v].two ^ (r[0] & VEC[v].slow));
    end
    slow = 1'b0;

    // fill limit, word stepping, drain to empty
    step(1'b1, 32'h40, 1'b0, 1'b0);
    chk(!op_valid8, "R7 flush after redirect", 32'(op_valid8), 0);
    repeat (10) step(1'b0, 0, 1'b0, 1'b0);
    chk(!mem_req_valid, "R5 no request with 4 bytes held", 32'(mem_req_valid), 0);
    chk(mem_req_addr == 30'h11, "R6 address advanced once", 32'(mem_req_addr), 32'h11);
    step(1'b0, 0, 1'b1, 1'b1);
    repeat (8) step(1'b0, 0, 1'b0, 1'b0);
    chk(!mem_req_valid, "R5 no request when full", 32'(mem_req_valid), 0);
    mem_en = 1'b0;
    start = exp_pc;
    repeat (9) step(1'b0, 0, 1'b1, 1'b0);
    n = int'(exp_pc - start);
    chk(n == 6, "R5 six bytes held", 32'(n), 6);
    chk(mem_req_valid && mem_req_addr == 30'h12, "R10 request held unaccepted",
        32'(mem_req_addr), 32'h12);
    chk(!op_valid8, "R4 empty stall", 32'(op_valid8), 0);
    mem_en = 1'b1;

    // single byte held: pair take refused
    step(1'b1, 32'h83, 1'b0, 1'b0);
    n = 0;
    #2;
    while (!mem_rsp_valid && n < 10) begin
      step(1'b0, 0, 1'b0, 1'b0); #2; n++;
    end
    mem_en = 1'b0;
    step(1'b0, 0, 1'b0, 1'b0);
    chk(op_valid8 && !op_valid16 && op8 == pat(32'h83), "R3 one byte only",
        32'({op_valid8, op_valid16, op8}), 32'({2'b10, pat(32'h83)}));
    step(1'b0, 0, 1'b1, 1'b1);
    step(1'b0, 0, 1'b1, 1'b0);
    chk(!op_valid8, "R4 single take empties", 32'(op_valid8), 0);
    mem_en = 1'b1;

    // stale response after redirect
    lat = 3;
    step(1'b1, 32'h200, 1'b0, 1'b0);
    #2;
    n = 0;
    while (!(mem_req_valid && mem_req_ready) && n < 10) begin
      step(1'b0, 0, 1'b0, 1'b0); #2; n++;
    end
    step(1'b0, 0, 1'b0, 1'b0);
    step(1'b1, 32'h305, 1'b0, 1'b0);
    repeat (12) step(1'b0, 0, 1'b0, 1'b0);
    chk(op_valid8 && op8 == pat(32'h305), "R8 stale word discarded", 32'(op8), 32'(pat(32'h305)));
    repeat (30) step(1'b0, 0, 1'b1, 1'b1);
    lat = 1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule